// File: doc/BRIEF.md
# Multi-Channel Edge Event Timestamper

This block gives software a time reference for signal transitions. It has twelve capture channels. Each channel picks one signal from a shared pool that holds the external pins and the internal strobe lines. Each channel then waits for a rising edge, a falling edge or either edge on that signal. When an enabled channel sees a qualifying transition, it stores the current value of a free-running cycle counter. It also sets its pending flag. The pending flags are combined with a per-channel enable mask to drive one interrupt line. Software acknowledges a channel by writing a one to that channel's bit in the acknowledge register.

Every pool input passes through a two-stage synchronizer. Edges are detected once, across the whole pool, before any channel selects its source. Because of this, changing a channel's source never creates an event on its own. If a channel captures again while its pending flag is still set, the new stamp replaces the old one and a sticky overrun flag is set. That overrun flag is cleared by the same acknowledge that clears the pending flag.

All control and status go through a plain single-cycle register port with no handshake. A write takes effect at the clock edge where `reg_we_i` is high. Read data is a combinational function of `reg_addr_i`, so no cycle can stall or be back-pressured.

Top module: `ets_timestamper`

## Requirements
- R1: A TS_W-bit time counter (TS_W is 32 by default) clears to 0 on reset and increases by one on every clock. It reads at address 0x25.
- R2: After reset, every channel config, the pending word (0x20), the overrun word (0x23), the interrupt mask (0x21) and every stamp read 0, and `irq_o` is low.
- R3: Config field bits [5:0] select the source. Codes 0..NUM_PINS-1 select `pin_i[code]`. Codes NUM_PINS..NUM_PINS+NUM_INT-1 select `int_sig_i[code-NUM_PINS]`. Every higher code is a constant 0 and never produces an event.
- R4: Config bits [7:6] give the edge mode: 01 rising, 10 falling, 11 both, 00 none. Config bit 8 arms the channel. A transition that is disarmed or does not match the mode leaves the stamp and the pending bit unchanged.
- R5: Take the counter value C read in the cycle a source input changes. The captured stamp is C+2, and the pending bit is visible from the third cycle after the change.
- R6: The pending word at 0x20 has bit u set exactly for each channel u that holds an unacknowledged capture.
- R7: `irq_o` is high exactly when the pending word ANDed with the mask register at 0x21 is nonzero.
- R8: Writing to 0x22 clears pending and overrun for each channel whose data bit is 1, and zero bits have no effect. If a capture lands in the same cycle as its clear, the capture wins: pending stays 1, overrun reads 0 and the stamp is new.
- R9: A capture while pending is already set overwrites the stamp and sets that channel's bit in the overrun word at 0x23.
- R10: Address 0x24 returns the synchronized levels of `int_sig_i`, two clocks behind the pins.
- R11: Channel u's config reads back at address u, bits [8:0] with zero upper bits, and its stamp reads at address 0x10+u.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NUM_PINS | External pin sources (asynchronous) |
| int_sig_i | input | NUM_INT | Internal strobe sources |
| reg_addr_i | input | 6 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_we_i | input | 1 | Write strobe, one cycle per write |
| reg_rdata_o | output | 32 | Combinational read data for `reg_addr_i` |
| irq_o | output | 1 | Shared interrupt request |

## Verification
The bench sweeps all 64 source codes through every edge mode, both armed and disarmed. For each combination it drives a rising transition and then a falling one. This separates pin codes from internal codes from dead codes, and it also separates a matching edge from a mismatched edge and from a disarmed channel. Each result is checked through the full pending word, so a capture on the wrong channel shows up as well. Separate sequences check the capture-over-pending overwrite, zero-bit and foreign-bit acknowledges, mask gating of the interrupt, and a clear that lands on the same edge as a new capture. These sequences tell "event wins" apart from "clear wins". The internal-level read is sampled one and two cycles after a change to pin down the synchronizer depth.

// File: rtl/ets_pkg.sv
package ets_pkg;
  localparam int REG_AW = 6;
  localparam int REG_DW = 32;
  localparam int SRC_W  = 6;
  localparam int POOL_N = 1 << SRC_W;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_mode_e;

  typedef struct packed {
    logic             arm;
    edge_mode_e       mode;
    logic [SRC_W-1:0] src;
  } unit_cfg_t;

  localparam int CFG_W = $bits(unit_cfg_t);

  localparam logic [REG_AW-1:0] A_STAMP_BASE = 6'h10;
  localparam logic [REG_AW-1:0] A_PEND       = 6'h20;
  localparam logic [REG_AW-1:0] A_IRQ_MASK   = 6'h21;
  localparam logic [REG_AW-1:0] A_ACK        = 6'h22;
  localparam logic [REG_AW-1:0] A_OVR        = 6'h23;
  localparam logic [REG_AW-1:0] A_LEVEL      = 6'h24;
  localparam logic [REG_AW-1:0] A_TIME       = 6'h25;
endpackage

// File: rtl/ets_sync.sv
module ets_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] chain_q;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= '0;
          else        chain_q[s] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= '0;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ets_edge_front.sv
module ets_edge_front import ets_pkg::*; #(
  parameter int NUM_PINS = 16,
  parameter int NUM_INT  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic [NUM_INT-1:0]  int_i,
  output logic [POOL_N-1:0]   rise_o,
  output logic [POOL_N-1:0]   fall_o,
  output logic [NUM_INT-1:0]  int_lvl_o
);
  localparam int RAW_N = NUM_PINS + NUM_INT;

  logic [RAW_N-1:0] raw_w;
  logic [RAW_N-1:0] synced_w;
  logic [RAW_N-1:0] prev_q;

  assign raw_w = {int_i, pin_i};

  ets_sync #(.W(RAW_N), .STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (raw_w),
    .q_o   (synced_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= synced_w;
  end

  genvar i;
  generate
    for (i = 0; i < POOL_N; i++) begin : g_pool
      if (i < RAW_N) begin : g_live
        assign rise_o[i] =  synced_w[i] & ~prev_q[i];
        assign fall_o[i] = ~synced_w[i] &  prev_q[i];
      end else begin : g_dead
        assign rise_o[i] = 1'b0;
        assign fall_o[i] = 1'b0;
      end
    end
  endgenerate

  assign int_lvl_o = synced_w[RAW_N-1:NUM_PINS];
endmodule

// File: rtl/ets_unit.sv
module ets_unit import ets_pkg::*; #(
  parameter int TS_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  unit_cfg_t         cfg_i,
  input  logic [POOL_N-1:0] rise_i,
  input  logic [POOL_N-1:0] fall_i,
  input  logic [TS_W-1:0]   ts_i,
  input  logic              ack_i,
  output logic              hit_o,
  output logic              pend_o,
  output logic              ovr_o,
  output logic [TS_W-1:0]   stamp_o
);
  logic sel_rise, sel_fall;

  assign sel_rise = rise_i[cfg_i.src];
  assign sel_fall = fall_i[cfg_i.src];
  assign hit_o    = cfg_i.arm &
                    ((cfg_i.mode[0] & sel_rise) | (cfg_i.mode[1] & sel_fall));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stamp_o <= '0;
      pend_o  <= 1'b0;
      ovr_o   <= 1'b0;
    end else if (hit_o) begin
      stamp_o <= ts_i;
      pend_o  <= 1'b1;
      ovr_o   <= ack_i ? 1'b0 : (ovr_o | pend_o);
    end else if (ack_i) begin
      pend_o  <= 1'b0;
      ovr_o   <= 1'b0;
    end
  end
endmodule

// File: rtl/ets_regs.sv
module ets_regs import ets_pkg::*; #(
  parameter int NUM_UNITS = 12,
  parameter int NUM_INT   = 8,
  parameter int TS_W      = 32
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [REG_AW-1:0]                   addr_i,
  input  logic [REG_DW-1:0]                   wdata_i,
  input  logic                                we_i,
  output logic [REG_DW-1:0]                   rdata_o,
  output unit_cfg_t [NUM_UNITS-1:0]           cfg_o,
  output logic [NUM_UNITS-1:0]                ack_o,
  input  logic [NUM_UNITS-1:0]                pend_i,
  input  logic [NUM_UNITS-1:0]                ovr_i,
  input  logic [NUM_UNITS-1:0][TS_W-1:0]      stamp_i,
  input  logic [NUM_INT-1:0]                  lvl_i,
  input  logic [TS_W-1:0]                     ts_i,
  output logic                                irq_o
);
  logic [NUM_UNITS-1:0] mask_q;
  logic                 unused_wdata;

  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_o  <= '0;
      mask_q <= '0;
    end else if (we_i) begin
      for (int u = 0; u < NUM_UNITS; u++) begin
        if (addr_i == REG_AW'(u)) cfg_o[u] <= unit_cfg_t'(wdata_i[CFG_W-1:0]);
      end
      if (addr_i == A_IRQ_MASK) mask_q <= wdata_i[NUM_UNITS-1:0];
    end
  end

  assign ack_o = (we_i && addr_i == A_ACK) ? wdata_i[NUM_UNITS-1:0] : '0;
  assign irq_o = |(pend_i & mask_q);

  always_comb begin
    rdata_o = '0;
    for (int u = 0; u < NUM_UNITS; u++) begin
      if (addr_i == REG_AW'(u))                rdata_o = REG_DW'(cfg_o[u]);
      if (addr_i == A_STAMP_BASE + REG_AW'(u)) rdata_o = REG_DW'(stamp_i[u]);
    end
    case (addr_i)
      A_PEND:     rdata_o = REG_DW'(pend_i);
      A_IRQ_MASK: rdata_o = REG_DW'(mask_q);
      A_OVR:      rdata_o = REG_DW'(ovr_i);
      A_LEVEL:    rdata_o = REG_DW'(lvl_i);
      A_TIME:     rdata_o = REG_DW'(ts_i);
      default:    ;
    endcase
  end
endmodule

// File: rtl/ets_timestamper.sv
module ets_timestamper import ets_pkg::*; #(
  parameter int NUM_UNITS = 12,
  parameter int NUM_PINS  = 16,
  parameter int NUM_INT   = 8,
  parameter int TS_W      = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic [NUM_INT-1:0]  int_sig_i,
  input  logic [REG_AW-1:0]   reg_addr_i,
  input  logic [REG_DW-1:0]   reg_wdata_i,
  input  logic                reg_we_i,
  output logic [REG_DW-1:0]   reg_rdata_o,
  output logic                irq_o
);
  logic [TS_W-1:0]                 ts_q;
  logic [POOL_N-1:0]               rise_w, fall_w;
  logic [NUM_INT-1:0]              lvl_w;
  unit_cfg_t [NUM_UNITS-1:0]       cfg_w;
  logic [NUM_UNITS-1:0]            ack_w, hit_w, pend_w, ovr_w;
  logic [NUM_UNITS-1:0][TS_W-1:0]  stamp_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ts_q <= '0;
    else        ts_q <= ts_q + TS_W'(1);
  end

  ets_edge_front #(.NUM_PINS(NUM_PINS), .NUM_INT(NUM_INT)) u_front (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_i     (pin_i),
    .int_i     (int_sig_i),
    .rise_o    (rise_w),
    .fall_o    (fall_w),
    .int_lvl_o (lvl_w)
  );

  genvar u;
  generate
    for (u = 0; u < NUM_UNITS; u++) begin : g_unit
      ets_unit #(.TS_W(TS_W)) u_unit (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_i   (cfg_w[u]),
        .rise_i  (rise_w),
        .fall_i  (fall_w),
        .ts_i    (ts_q),
        .ack_i   (ack_w[u]),
        .hit_o   (hit_w[u]),
        .pend_o  (pend_w[u]),
        .ovr_o   (ovr_w[u]),
        .stamp_o (stamp_w[u])
      );
    end
  endgenerate

  ets_regs #(.NUM_UNITS(NUM_UNITS), .NUM_INT(NUM_INT), .TS_W(TS_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .we_i    (reg_we_i),
    .rdata_o (reg_rdata_o),
    .cfg_o   (cfg_w),
    .ack_o   (ack_w),
    .pend_i  (pend_w),
    .ovr_i   (ovr_w),
    .stamp_i (stamp_w),
    .lvl_i   (lvl_w),
    .ts_i    (ts_q),
    .irq_o   (irq_o)
  );
endmodule

// File: rtl/ets_checker.sv
module ets_checker #(
  parameter int NUM_UNITS = 12,
  parameter int TS_W      = 32
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           irq_i,
  input logic [NUM_UNITS-1:0]           pend_i,
  input logic [NUM_UNITS-1:0]           ovr_i,
  input logic [NUM_UNITS-1:0]           hit_i,
  input logic [NUM_UNITS-1:0]           ack_i,
  input logic [TS_W-1:0]                ts_i,
  input logic [NUM_UNITS-1:0][TS_W-1:0] stamp_i
);
  // R1: counter advances by one per clock once out of reset
  p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (ts_i == $past(ts_i) + TS_W'(1)));

  // R7: interrupt only with some channel pending
  p_irq_needs_pend_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_i |-> (pend_i != '0));

  // R9: overrun never stands without its pending bit
  p_ovr_with_pend_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((ovr_i & ~pend_i) == '0));

  // R6: a pending bit rises only after a capture
  p_no_spurious_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_i == '0) |=> ((pend_i & ~$past(pend_i)) == '0));

  // R8: acknowledged channel without a capture is idle next cycle
  p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((ack_i & ~hit_i) != '0) |=> ((pend_i & $past(ack_i & ~hit_i)) == '0));

  // R5: stamps hold when nothing is captured
  p_stamp_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_i == '0) |=> $stable(stamp_i));
endmodule

bind ets_timestamper ets_checker #(.NUM_UNITS(NUM_UNITS), .TS_W(TS_W)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .irq_i   (irq_o),
  .pend_i  (pend_w),
  .ovr_i   (ovr_w),
  .hit_i   (hit_w),
  .ack_i   (ack_w),
  .ts_i    (ts_q),
  .stamp_i (stamp_w)
);

// File: tb/ets_timestamper_tb_top.sv
module ets_timestamper_tb_top;
  localparam int NU = 12;
  localparam int NP = 16;
  localparam int NI = 8;
  localparam logic [5:0] A_STAMP = 6'h10, A_PEND = 6'h20, A_MASK = 6'h21,
                         A_ACK = 6'h22, A_OVR = 6'h23, A_LVL = 6'h24, A_TIME = 6'h25;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n;
  logic [NP-1:0] pins;
  logic [NI-1:0] ints;
  logic [5:0]    addr;
  logic [31:0]   wdata;
  logic          we;
  logic [31:0]   rdata;
  logic          irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] exp_stamp [NU];

  ets_timestamper dut_i (
    .clk(clk), .rst_n(rst_n), .pin_i(pins), .int_sig_i(ints),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_we_i(we),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic set_src(input int code, input logic v);
    if (code < NP)           pins[code] = v;
    else if (code < NP + NI) ints[code-NP] = v;
    else begin pins = {NP{v}}; ints = {NI{v}}; end
  endtask

  // source already at ~nv and settled; channel u configured
  task automatic trial(input int u, input int code, input int mode, input bit arm, input logic nv);
    logic [31:0] c, v;
    bit fire;
    wr(A_ACK, 32'hFFF);
    rd(A_TIME, c);
    set_src(code, nv);
    repeat (2) @(negedge clk);
    fire = arm && (code < NP + NI) && ((nv && mode[0]) || (!nv && mode[1]));
    if (fire) exp_stamp[u] = c + 32'd2;
    rd(A_PEND, v);
    chk("R3 R4 R6 pending word", v, fire ? (32'd1 << u) : 32'd0);
    chk("R7 irq", {31'd0, irq}, {31'd0, fire});
    rd(A_STAMP + 6'(u), v);
    chk("R5 R11 stamp", v, exp_stamp[u]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired before the run finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, c, c2;
    for (int i = 0; i < NU; i++) exp_stamp[i] = '0;
    rst_n = 1'b0; pins = '0; ints = '0; addr = '0; wdata = '0; we = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2 reset state
    rd(A_PEND, v);  chk("R2 pending", v, 0);
    rd(A_OVR, v);   chk("R2 overrun", v, 0);
    rd(A_MASK, v);  chk("R2 mask", v, 0);
    rd(6'h00, v);   chk("R2 config", v, 0);
    rd(A_STAMP, v); chk("R2 stamp", v, 0);
    chk("R2 irq", {31'd0, irq}, 0);

    // R1 counter step
    rd(A_TIME, c); rd(A_TIME, c2);
    chk("R1 counter step", c2, c + 32'd1);

    // R11 config readback
    wr(6'd7, 32'hFFFF_FFFF);
    rd(6'd7, v); chk("R11 config readback", v, 32'h1FF);
    wr(6'd7, 32'd0);

    // R3 R4 sweep over every code, mode and arm
    wr(A_MASK, 32'hFFF);
    for (int code = 0; code < 64; code++) begin
      for (int mode = 0; mode < 4; mode++) begin
        for (int arm = 0; arm < 2; arm++) begin
          int u;
          u = code % NU;
          wr(6'(u), 32'd0);
          set_src(code, 1'b0);
          repeat (3) @(negedge clk);
          wr(6'(u), 32'((arm << 8) | (mode << 6) | code));
          trial(u, code, mode, arm[0], 1'b1);
          trial(u, code, mode, arm[0], 1'b0);
          wr(6'(u), 32'd0);
        end
      end
    end
    pins = '0; ints = '0;
    repeat (3) @(negedge clk);

    // R9 overrun on channel 2, pin 5, both edges
    wr(6'd2, 32'h1C5);
    wr(A_ACK, 32'hFFF);
    rd(A_TIME, c); pins[5] = 1'b1; repeat (2) @(negedge clk);
    rd(A_PEND, v); chk("R6 first capture", v, 32'h4);
    rd(A_OVR, v);  chk("R9 no overrun yet", v, 0);
    rd(A_TIME, c); pins[5] = 1'b0; repeat (2) @(negedge clk);
    rd(A_OVR, v);  chk("R9 overrun set", v, 32'h4);
    rd(A_STAMP + 6'd2, v); chk("R9 stamp overwritten", v, c + 32'd2);

    // R8 zero and foreign bits have no effect
    wr(A_ACK, 32'd0);
    rd(A_PEND, v); chk("R8 zero ack pending", v, 32'h4);
    wr(A_ACK, 32'hFFB);
    rd(A_OVR, v);  chk("R8 foreign ack overrun", v, 32'h4);

    // R7 mask gating
    wr(A_MASK, 32'd0); #1;
    chk("R7 masked irq", {31'd0, irq}, 0);
    wr(A_MASK, 32'h4); #1;
    chk("R7 unmasked irq", {31'd0, irq}, 1);

    // R8 clear
    wr(A_ACK, 32'h4);
    rd(A_PEND, v); chk("R8 pending cleared", v, 0);
    rd(A_OVR, v);  chk("R8 overrun cleared", v, 0);
    chk("R8 irq low", {31'd0, irq}, 0);

    // R8 capture and clear on the same edge
    pins[5] = 1'b1; repeat (3) @(negedge clk);
    rd(A_TIME, c); pins[5] = 1'b0;
    @(negedge clk);
    wr(A_ACK, 32'h4);
    rd(A_PEND, v); chk("R8 event wins pending", v, 32'h4);
    rd(A_OVR, v);  chk("R8 event wins overrun", v, 0);
    rd(A_STAMP + 6'd2, v); chk("R8 event wins stamp", v, c + 32'd2);
    wr(6'd2, 32'd0);

    // R10 internal level latency
    @(negedge clk); ints = 8'hA5;
    rd(A_LVL, v); chk("R10 level after one clock", v, 0);
    rd(A_LVL, v); chk("R10 level after two clocks", v, 32'hA5);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule